// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port (Master or Slave)

This block is a full-duplex synchronous serial port with one shift register and one receive buffer. It can act as the clock-owning master or as a slave clocked from outside. A 4-bit mode field, a clock polarity bit and an enable bit set up the port. Software writes a byte to load the shift register and reads the byte that arrived. The port shifts data most significant bit first. It samples the serial input on the edge that leaves the idle clock level and drives the next output bit on the edge that returns to idle.

As a master, a write starts a transfer. The bit clock comes from one of three system-clock dividers or from an external timer tick, with two ticks making one bit. A monitor setting turns off the clock output while the port keeps running, so it captures a byte from the serial input every eight bit times. As a slave, the port takes its serial clock through a synchronizer and can use an active-low select input. When a byte completes, the port raises a completion flag. It also reports a full buffer, a lost byte and a write made during a transfer.

Top module: `spi_port`

## Requirements
- R1: While `cfg_en` is 0, the completion, full, overflow and collision flags clear on the next clock and `sck_o` returns to the `cfg_cpol` level. After reset every flag is 0.
- R2: `cfg_mode[3:2]` = 00 selects master, 01 selects slave, and any other value leaves the port inert: no transfer, no flag, `sck_oe` and `sdo_oe` low. In slave mode `cfg_mode[0]` = 0 enables the select input and 1 ignores it.
- R3: A master write starts a transfer at once. Bit 7 is sent first and the byte sampled from `sdi` is received into the buffer, so with `sdi` tied to `sdo` the received byte equals the written one.
- R4: With `cfg_mode[1:0]` = 0, 1, 2 the master bit period is DIV_A, DIV_B or DIV_C system clocks, and with 3 it is two `tmr_tick` pulses. One byte therefore keeps `sck_o` at its active level for 8·DIV/2 clocks, or 8 tick periods.
- R5: `sck_o` idles at `cfg_cpol`. Input is sampled on the idle-to-active edge and output changes on the active-to-idle edge, so with `sdi` tied to the inverse of `sdo` the received byte is the complement of the sent one.
- R6: On the eighth bit the byte is copied into the buffer and `irq_o` is set. A `flag_clr` pulse clears `irq_o`.
- R7: `buf_full_o` sets when a byte is loaded and clears on `buf_rd`. A byte that completes while the buffer is full and not being read sets `ovf_o` and leaves `buf_rdata` unchanged.
- R8: A `buf_wr` while a transfer is in progress sets `wcol_o` and does not disturb the byte being shifted. `flag_clr` clears `wcol_o`.
- R9: In master mode with `cfg_sck_drive` = 0, `sck_oe` is 0 and the port keeps shifting without any write, loading each completed byte from `sdi` into the buffer.
- R10: In slave mode the port samples `sdi` on edges of the synchronized `sck_i` and presents the preloaded byte on `sdo`, bit 7 first.
- R11: In slave mode with select enabled, a high `ss_n_i` turns `sdo_oe` off and clock edges are ignored. Raising `ss_n_i` mid-byte restarts the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Port enable; low holds the port in reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_mode | input | 4 | Role and bit-rate / select option |
| cfg_sck_drive | input | 1 | Master drives its clock out (0 = monitor) |
| buf_wr | input | 1 | Write strobe: load shift register |
| buf_wdata | input | DATA_W | Byte to send |
| buf_rd | input | 1 | Read strobe: clears buffer-full |
| buf_rdata | output | DATA_W | Last received byte |
| flag_clr | input | 1 | Clears completion, overflow and collision flags |
| tmr_tick | input | 1 | External timer tick for the slowest rate option |
| sck_o | output | 1 | Master serial clock |
| sck_oe | output | 1 | Enable for the master clock output |
| sck_i | input | 1 | Serial clock from an external master |
| ss_n_i | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Enable for the data output |
| irq_o | output | 1 | Transfer complete |
| buf_full_o | output | 1 | Unread byte in buffer |
| ovf_o | output | 1 | Byte lost while buffer full |
| wcol_o | output | 1 | Write during transfer |

## Verification
The hardest state to reach is a slave byte broken off by the select input. The port must have taken some bits and then see the select rise before the eighth edge. The bench drives `sck_i` by hand for only three bits, raises `ss_n_i`, and then clocks a full byte that the port must ignore. It then lowers the select and sends a fresh byte, which must arrive intact, so a stale bit count would show as a corrupted value. Overflow is reached by completing two master transfers with no read in between.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   typedef enum logic [1:0] {
      ROLE_OFF    = 2'd0,
      ROLE_MASTER = 2'd1,
      ROLE_SLAVE  = 2'd2
   } role_e;

   typedef struct packed {
      role_e      role;
      logic [1:0] rate;
      logic       ss_en;
   } cfg_t;

   // R2: upper mode bits pick the role, lower bits pick rate or select use
   function automatic cfg_t decode_mode(input logic [3:0] m);
      cfg_t c;
      c.rate  = m[1:0];
      c.ss_en = ~m[0];
      case (m[3:2])
         2'b00:   c.role = ROLE_MASTER;
         2'b01:   c.role = ROLE_SLAVE;
         default: c.role = ROLE_OFF;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff_q[0] <= RST_VAL;
               else        ff_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff_q[i] <= RST_VAL;
               else        ff_q[i] <= ff_q[i-1];
            end
         end
      end
   endgenerate

   assign q = ff_q[STAGES-1];
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
   parameter int DIV_A    = 4,
   parameter int DIV_B    = 16,
   parameter int DIV_C    = 64,
   parameter bit USE_TICK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate,
   input  logic       tick,
   output logic       strobe
);
   localparam int HALF_A = DIV_A / 2;
   localparam int HALF_B = DIV_B / 2;
   localparam int HALF_C = DIV_C / 2;
   localparam int CNT_W  = $clog2(HALF_C + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;
   logic             div_hit;

   // R4: half bit period per rate selection
   always_comb begin
      case (rate)
         2'd0:    half_m1 = CNT_W'(HALF_A - 1);
         2'd1:    half_m1 = CNT_W'(HALF_B - 1);
         default: half_m1 = CNT_W'(HALF_C - 1);
      endcase
   end

   assign div_hit = (cnt_q == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (div_hit)  cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (USE_TICK) begin : g_tick
         assign strobe = run & ((rate == 2'd3) ? tick : div_hit);
      end else begin : g_notick
         assign strobe = run & div_hit;
      end
   endgenerate
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         abort,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         lead,
   input  logic         trail,
   input  logic         sdi,
   output logic         msb,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] rx_data
);
   localparam int              CW   = $clog2(W + 1);
   localparam logic [CW-1:0]   LAST = CW'(W - 1);

   logic [W-1:0]  sh_q;
   logic          cap_q;
   logic          half_q;
   logic [CW-1:0] cnt_q;

   assign msb     = sh_q[W-1];
   assign busy    = half_q | (cnt_q != '0);
   assign rx_data = {sh_q[W-2:0], cap_q};
   // R6: last trailing edge of the byte
   assign done    = trail & half_q & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cap_q  <= 1'b0;
         half_q <= 1'b0;
         cnt_q  <= '0;
      end else if (clr) begin
         sh_q   <= '0;
         cap_q  <= 1'b0;
         half_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (load) sh_q <= load_data;
         if (abort) begin
            // R11: select raised, restart the byte
            half_q <= 1'b0;
            cnt_q  <= '0;
         end else if (lead && !half_q) begin
            // R5: sample on leading edge
            cap_q  <= sdi;
            half_q <= 1'b1;
         end else if (trail && half_q) begin
            // R3: shift toward the MSB, next bit appears on msb
            sh_q   <= rx_data;
            half_q <= 1'b0;
            cnt_q  <= done ? '0 : cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_port_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int DIV_A          = 4,
   parameter int DIV_B          = 16,
   parameter int DIV_C          = 64,
   parameter int SYNC_STAGES    = 2,
   parameter bit USE_TIMER_TICK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_cpol,
   input  logic [3:0]        cfg_mode,
   input  logic              cfg_sck_drive,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   input  logic              buf_rd,
   output logic [DATA_W-1:0] buf_rdata,
   input  logic              flag_clr,
   input  logic              tmr_tick,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              sck_i,
   input  logic              ss_n_i,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              irq_o,
   output logic              buf_full_o,
   output logic              ovf_o,
   output logic              wcol_o
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("spi_port: DATA_W must be at least 2");
      end
      if ((DIV_A % 2) != 0 || (DIV_B % 2) != 0 || (DIV_C % 2) != 0 || DIV_A < 2) begin : g_bad_div
         $error("spi_port: dividers must be even and at least 2");
      end
      if (!(DIV_A <= DIV_B && DIV_B <= DIV_C)) begin : g_bad_order
         $error("spi_port: dividers must be non-decreasing");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_port: at least two synchronizer stages required");
      end
   endgenerate

   cfg_t cfg;
   assign cfg = decode_mode(cfg_mode);

   logic is_master, is_slave, active, monitor;
   assign is_master = cfg_en & (cfg.role == ROLE_MASTER);
   assign is_slave  = cfg_en & (cfg.role == ROLE_SLAVE);
   assign active    = is_master | is_slave;
   // R9: master with clock output off runs continuously
   assign monitor   = is_master & ~cfg_sck_drive;

   // ---------------- master clock ----------------
   logic run_q, m_run, m_strobe, sck_q, m_lead, m_trail;
   assign m_run = is_master & (run_q | monitor);

   spi_port_clkgen #(
      .DIV_A   (DIV_A),
      .DIV_B   (DIV_B),
      .DIV_C   (DIV_C),
      .USE_TICK(USE_TIMER_TICK)
   ) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (m_run),
      .rate  (cfg.rate),
      .tick  (tmr_tick),
      .strobe(m_strobe)
   );

   // R5: leading edge leaves the idle level, trailing edge returns to it
   assign m_lead  = m_strobe & (sck_q == cfg_cpol);
   assign m_trail = m_strobe & (sck_q != cfg_cpol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sck_q <= 1'b0;
      else if (!m_run)   sck_q <= cfg_cpol;
      else if (m_strobe) sck_q <= ~sck_q;
   end

   // ---------------- slave clock and select ----------------
   logic sck_s, ss_s, sck_prev_q, ss_block, s_lead, s_trail;

   spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s)
   );
   spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
      .clk(clk), .rst_n(rst_n), .d(ss_n_i), .q(ss_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev_q <= 1'b0;
      else        sck_prev_q <= sck_s;
   end

   // R11: deselected slave ignores the clock
   assign ss_block = is_slave & cfg.ss_en & ss_s;
   // R10: edges of the synchronized clock
   assign s_lead  = is_slave & ~ss_block & (sck_prev_q == cfg_cpol) & (sck_s != cfg_cpol);
   assign s_trail = is_slave & ~ss_block & (sck_prev_q != cfg_cpol) & (sck_s == cfg_cpol);

   // ---------------- shift register ----------------
   logic              lead, trail, sh_busy, sh_done, busy, accept_wr, collide, sh_msb;
   logic [DATA_W-1:0] sh_rx;

   assign lead      = m_lead | s_lead;
   assign trail     = m_trail | s_trail;
   assign busy      = sh_busy | run_q;
   assign accept_wr = buf_wr & active & ~busy;
   // R8: write during a transfer is refused
   assign collide   = buf_wr & active & busy;

   spi_port_shifter #(.W(DATA_W)) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~active),
      .abort    (ss_block),
      .load     (accept_wr),
      .load_data(buf_wdata),
      .lead     (lead),
      .trail    (trail),
      .sdi      (sdi),
      .msb      (sh_msb),
      .busy     (sh_busy),
      .done     (sh_done),
      .rx_data  (sh_rx)
   );

   // R3: a master write starts the transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     run_q <= 1'b0;
      else if (!is_master)            run_q <= 1'b0;
      else if (accept_wr && !monitor) run_q <= 1'b1;
      else if (sh_done)               run_q <= 1'b0;
   end

   // ---------------- buffer and flags ----------------
   logic [DATA_W-1:0] buf_q;
   logic              irq_q, full_q, ovf_q, wcol_q, lose, load_buf;

   // R7: a completed byte is dropped only if the buffer stays full
   assign lose     = sh_done & full_q & ~buf_rd;
   assign load_buf = sh_done & ~lose;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         irq_q  <= 1'b0;
         full_q <= 1'b0;
         ovf_q  <= 1'b0;
         wcol_q <= 1'b0;
      end else if (!cfg_en) begin
         // R1: disabled port clears its flags
         irq_q  <= 1'b0;
         full_q <= 1'b0;
         ovf_q  <= 1'b0;
         wcol_q <= 1'b0;
      end else begin
         if (load_buf) buf_q <= sh_rx;
         irq_q  <= sh_done | (irq_q & ~flag_clr);
         full_q <= sh_done | (full_q & ~buf_rd);
         ovf_q  <= lose | (ovf_q & ~flag_clr);
         wcol_q <= collide | (wcol_q & ~flag_clr);
      end
   end

   assign buf_rdata  = buf_q;
   assign irq_o      = irq_q;
   assign buf_full_o = full_q;
   assign ovf_o      = ovf_q;
   assign wcol_o     = wcol_q;
   assign sck_o      = sck_q;
   assign sck_oe     = is_master & cfg_sck_drive;
   assign sdo        = sh_msb;
   assign sdo_oe     = is_master | (is_slave & ~ss_block);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic              cfg_cpol,
   input logic              buf_wr,
   input logic [DATA_W-1:0] buf_rdata,
   input logic              sck_o,
   input logic              sdo_oe,
   input logic              irq_o,
   input logic              buf_full_o,
   input logic              ovf_o,
   input logic              wcol_o,
   input logic              ss_block,
   input logic              lead,
   input logic              trail
);
   // R1
   dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (!irq_o && !buf_full_o && !ovf_o && !wcol_o));

   // R5
   dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (sck_o == $past(cfg_cpol)));

   // R7
   ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> $past(buf_full_o));

   // R7
   ovf_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> $stable(buf_rdata));

   // R8
   wcol_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wcol_o) |-> $past(buf_wr));

   // R11
   ss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_block |-> !sdo_oe);

   // R5
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lead, trail}));
endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_en    (cfg_en),
   .cfg_cpol  (cfg_cpol),
   .buf_wr    (buf_wr),
   .buf_rdata (buf_rdata),
   .sck_o     (sck_o),
   .sdo_oe    (sdo_oe),
   .irq_o     (irq_o),
   .buf_full_o(buf_full_o),
   .ovf_o     (ovf_o),
   .wcol_o    (wcol_o),
   .ss_block  (ss_block),
   .lead      (lead),
   .trail     (trail)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
   localparam int TPER = 5;
   localparam int SH   = 8;

   logic       clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_sck_drive = 1'b1;
   logic [3:0] cfg_mode = 4'b0000;
   logic       buf_wr = 1'b0, buf_rd = 1'b0, flag_clr = 1'b0;
   logic [7:0] buf_wdata = 8'h00;
   logic [7:0] buf_rdata;
   logic       tmr_tick = 1'b0;
   logic       sck_o, sck_oe, sdo, sdo_oe;
   logic       sck_i = 1'b0, ss_n_i = 1'b1;
   logic       irq_o, buf_full_o, ovf_o, wcol_o;
   logic [1:0] lb_sel = 2'd0;
   logic       tb_sdi = 1'b0;
   logic       sdi_w;
   logic [7:0] s_cap;

   assign sdi_w = (lb_sel == 2'd0) ? sdo : (lb_sel == 2'd1) ? ~sdo : tb_sdi;

   spi_port u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
      .cfg_mode(cfg_mode), .cfg_sck_drive(cfg_sck_drive),
      .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
      .buf_rdata(buf_rdata), .flag_clr(flag_clr), .tmr_tick(tmr_tick),
      .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .ss_n_i(ss_n_i),
      .sdi(sdi_w), .sdo(sdo), .sdo_oe(sdo_oe), .irq_o(irq_o),
      .buf_full_o(buf_full_o), .ovf_o(ovf_o), .wcol_o(wcol_o)
   );

   int tcnt = 0;
   always @(negedge clk) begin
      if (tcnt == TPER - 1) begin tcnt <= 0; tmr_tick <= 1'b1; end
      else begin tcnt <= tcnt + 1; tmr_tick <= 1'b0; end
   end

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 180000) begin
         checks++; errors++;
         $display("FAIL watchdog (R1..) actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic setup(input logic cp, input logic [3:0] mode, input logic drive);
      @(negedge clk); cfg_en = 1'b0;
      repeat (2) @(negedge clk);
      cfg_cpol = cp; cfg_mode = mode; cfg_sck_drive = drive; sck_i = cp;
      repeat (4) @(negedge clk);
      cfg_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); buf_wr = 1'b1; buf_wdata = d;
      @(negedge clk); buf_wr = 1'b0;
   endtask

   task automatic clr_rd();
      @(negedge clk); flag_clr = 1'b1; buf_rd = 1'b1;
      @(negedge clk); flag_clr = 1'b0; buf_rd = 1'b0;
   endtask

   task automatic wait_irq();
      int n = 0;
      while (!irq_o && n < 4000) begin @(negedge clk); n++; end
   endtask

   // master transfer; exp_act < 0 skips the bit-rate check
   task automatic m_xfer(input logic [7:0] tx, input logic [7:0] exp_rx,
                         input int exp_act, input string tag, input bit do_read);
      int act = 0;
      int n = 0;
      wr(tx);
      while (!irq_o && n < 4000) begin
         if (sck_o != cfg_cpol) act++;
         n++;
         @(negedge clk);
      end
      check("R6 irq after byte", {31'd0, irq_o}, 32'd1);
      check(tag, {24'd0, buf_rdata}, {24'd0, exp_rx});
      if (exp_act >= 0) check("R4 active clocks", act, exp_act);
      if (do_read) begin
         clr_rd();
         check("R6 irq cleared", {31'd0, irq_o}, 32'd0);
         check("R7 full cleared by read", {31'd0, buf_full_o}, 32'd0);
      end
   endtask

   task automatic s_xfer(input logic [7:0] rx_in, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         tb_sdi = rx_in[i];
         repeat (SH) @(negedge clk);
         sck_i = ~cfg_cpol;
         repeat (SH - 1) @(negedge clk);
         s_cap[i] = sdo;
         @(negedge clk);
         sck_i = cfg_cpol;
      end
      repeat (SH) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq reset", {31'd0, irq_o}, 32'd0);
      check("R1 full reset", {31'd0, buf_full_o}, 32'd0);
      check("R1 ovf reset", {31'd0, ovf_o}, 32'd0);
      check("R1 wcol reset", {31'd0, wcol_o}, 32'd0);
      check("R1 buf reset", {24'd0, buf_rdata}, 32'd0);

      // R2 inert mode code 10xx
      setup(1'b0, 4'b1000, 1'b1);
      wr(8'h55);
      repeat (100) @(negedge clk);
      check("R2 inert irq", {31'd0, irq_o}, 32'd0);
      check("R2 inert sck_oe", {31'd0, sck_oe}, 32'd0);
      check("R2 inert sdo_oe", {31'd0, sdo_oe}, 32'd0);
      check("R2 inert wcol", {31'd0, wcol_o}, 32'd0);

      // R3 exhaustive loopback sweep at the fastest rate
      setup(1'b0, 4'b0000, 1'b1);
      check("R2 master sck_oe", {31'd0, sck_oe}, 32'd1);
      lb_sel = 2'd0;
      for (int v = 0; v < 256; v++) m_xfer(8'(v), 8'(v), DIV_A_HALF() * 8, "R3 loopback byte", 1'b1);

      // R5 inverted loopback: sample and drive edges are opposite
      lb_sel = 2'd1;
      for (int v = 0; v < 16; v++) begin
         logic [7:0] t;
         t = 8'(v * 17) ^ 8'h3C;
         m_xfer(t, ~t, 16, "R5 inverted loopback", 1'b1);
      end

      // R5 idle high polarity
      setup(1'b1, 4'b0000, 1'b1);
      check("R5 idle level high", {31'd0, sck_o}, 32'd1);
      lb_sel = 2'd0;
      m_xfer(8'hC3, 8'hC3, 16, "R5 cpol1 loopback", 1'b1);
      lb_sel = 2'd1;
      m_xfer(8'h96, 8'h69, 16, "R5 cpol1 inverted", 1'b1);
      check("R5 idle after byte", {31'd0, sck_o}, 32'd1);

      // R4 every bit-rate option
      lb_sel = 2'd0;
      for (int r = 0; r < 4; r++) begin
         int half;
         half = (r == 0) ? 2 : (r == 1) ? 8 : (r == 2) ? 32 : TPER;
         setup(1'b0, {2'b00, 2'(r)}, 1'b1);
         m_xfer(8'h5A ^ 8'(r), 8'h5A ^ 8'(r), 8 * half, "R4 rate byte", 1'b1);
      end

      // R7 overflow: two bytes, no read between
      setup(1'b0, 4'b0000, 1'b1);
      m_xfer(8'h11, 8'h11, -1, "R7 first byte", 1'b0);
      wr(8'h22);
      repeat (60) @(negedge clk);
      check("R7 ovf set", {31'd0, ovf_o}, 32'd1);
      check("R7 buf kept", {24'd0, buf_rdata}, 32'h11);
      check("R7 still full", {31'd0, buf_full_o}, 32'd1);
      @(negedge clk); buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0;
      check("R7 read clears full", {31'd0, buf_full_o}, 32'd0);
      check("R7 ovf holds until clear", {31'd0, ovf_o}, 32'd1);

      // R1 disabling clears the flags
      @(negedge clk); cfg_en = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 disable ovf", {31'd0, ovf_o}, 32'd0);
      check("R1 disable irq", {31'd0, irq_o}, 32'd0);
      check("R1 disable sdo_oe", {31'd0, sdo_oe}, 32'd0);

      // R8 write collision
      setup(1'b0, 4'b0000, 1'b1);
      wr(8'h81);
      repeat (6) @(negedge clk);
      wr(8'h7E);
      check("R8 wcol set", {31'd0, wcol_o}, 32'd1);
      wait_irq();
      check("R8 byte undisturbed", {24'd0, buf_rdata}, 32'h81);
      clr_rd();
      check("R8 wcol cleared", {31'd0, wcol_o}, 32'd0);

      // R9 monitor mode
      lb_sel = 2'd2; tb_sdi = 1'b1;
      setup(1'b0, 4'b0000, 1'b0);
      check("R9 clock output off", {31'd0, sck_oe}, 32'd0);
      wait_irq();
      check("R9 ones captured", {24'd0, buf_rdata}, 32'hFF);
      clr_rd();
      tb_sdi = 1'b0;
      wait_irq(); clr_rd();
      wait_irq();
      check("R9 zeros captured", {24'd0, buf_rdata}, 32'h00);
      clr_rd();

      // R10 slave sweep, select ignored (mode 0101) with ss_n high
      ss_n_i = 1'b1;
      for (int cp = 0; cp < 2; cp++) begin
         setup(1'(cp), 4'b0101, 1'b1);
         check("R2 select ignored sdo_oe", {31'd0, sdo_oe}, 32'd1);
         for (int k = 0; k < 6; k++) begin
            logic [7:0] tx, rx;
            tx = 8'(k * 37 + 5);
            rx = 8'(k * 53 + 11);
            wr(tx);
            s_xfer(rx, 8);
            check("R10 slave rx", {24'd0, buf_rdata}, {24'd0, rx});
            check("R10 slave tx", {24'd0, s_cap}, {24'd0, tx});
            check("R6 slave irq", {31'd0, irq_o}, 32'd1);
            clr_rd();
         end
      end

      // R11 select-enabled slave, byte broken off mid-way
      ss_n_i = 1'b0;
      setup(1'b0, 4'b0100, 1'b1);
      wr(8'hA0);
      s_xfer(8'hE0, 3);
      ss_n_i = 1'b1;
      repeat (6) @(negedge clk);
      check("R11 sdo released", {31'd0, sdo_oe}, 32'd0);
      s_xfer(8'hFF, 8);
      check("R11 clock ignored", {31'd0, irq_o}, 32'd0);
      ss_n_i = 1'b0;
      repeat (6) @(negedge clk);
      check("R11 sdo driven", {31'd0, sdo_oe}, 32'd1);
      s_xfer(8'h3C, 8);
      check("R11 count restarted", {24'd0, buf_rdata}, 32'h3C);
      check("R11 irq after full byte", {31'd0, irq_o}, 32'd1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   function automatic int DIV_A_HALF();
      return 2;
   endfunction
endmodule